// File: doc/BRIEF.md
# DS3 M-Frame Overhead Generator

This block builds the serial DS3 bit stream of the transmit direction. It keeps the M-frame position in three nested counters: bit within a block, block within a subframe, and subframe within the M-frame. At the first bit time of every 85-bit block it puts out an overhead bit. For the other 84 bit times it passes one payload bit through from a valid/ready input stream. One M-frame is 7 subframes of 8 blocks, so 4760 bits in all, and 56 of those bits are overhead.

There are several kinds of overhead bit. The F and M alignment patterns are fixed. The two X bits come from a pin. The two P bits are computed: they carry the parity of the payload sent in the previous M-frame. The 21 C bits change with the mode. In C-bit parity mode they come from a supplied vector, with the first C bit forced high. In M13 mode each subframe repeats its stuff indicator in all three of its C bits.

Both ends of the stream use valid/ready. The output side back-pressures with `ds3_ready`. While `ds3_ready` is low, or while a payload slot waits for `pl_valid`, the position does not move and the output bit stays at the same frame position. A frame-sync input, when it is enabled, forces the current bit time to become the first bit of a new M-frame.

Top module: `ds3_mframe_gen`

## Requirements
- R1: The position counts one bit per output transfer (`ds3_valid && ds3_ready`). It steps through bit 0..84 of a block, then block 0..7 of a subframe, then subframe 0..6, and wraps to the start. `mf_start` is high only at subframe 0, block 0, bit 0. `sf_idx` and `blk_idx` give the current subframe and block.
- R2: Bit 0 of each block is an overhead slot, and `ds3_valid` is always 1 there. In the other 84 slots `ds3_valid = pl_valid`, `ds3_bit = pl_data`, and `pl_ready = ds3_ready`. `pl_ready` is 0 in overhead slots.
- R3: The overhead bits of blocks 1, 3, 5 and 7 are the F bits, with values 1, 0, 0, 1 in that order.
- R4: The overhead bit of block 0 is `x_bit` in subframes 0 and 1. In subframes 4, 5 and 6 it is 0, 1 and 0.
- R5: The overhead bit of block 0 in subframes 2 and 3 is the XOR of all payload bits sent in the last complete M-frame. It is 0 until the first M-frame completes.
- R6: In C-bit parity mode (`mode`=1), the overhead bit of block 2, 4 or 6 of subframe s is `c_bits[3*s+n]`, where n = 0, 1, 2 for those blocks. The one exception is `c_bits[0]`: that position always sends 1.
- R7: In M13 mode (`mode`=0), the overhead bits of blocks 2, 4 and 6 of subframe s all equal `stuff_ind[s]`.
- R8: A cycle with no output transfer leaves the position unchanged.
- R9: When `frame_sync` and `sync_en` are both 1, the current bit time is subframe 0, block 0, bit 0. The parity sum of the frame in progress is discarded.
- R10: `frame_sync` has no effect when `sync_en` is 0.
- R11: After reset the position is the first bit of an M-frame and the stored parity is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mode | input | 1 | 1 = C-bit parity mode, 0 = M13 mode |
| x_bit | input | 1 | Value of both X bits |
| c_bits | input | 21 | C-bit values for C-bit parity mode, index 3*subframe+n |
| stuff_ind | input | 7 | Per-subframe stuff indicator for M13 mode |
| sync_en | input | 1 | Enables the frame-sync input |
| frame_sync | input | 1 | Marks the current bit time as M-frame bit 0 |
| pl_valid | input | 1 | Payload bit available |
| pl_data | input | 1 | Payload bit |
| pl_ready | output | 1 | Payload bit accepted this cycle (payload slot and `ds3_ready`) |
| ds3_valid | output | 1 | Output bit valid |
| ds3_ready | input | 1 | Downstream accepts the output bit |
| ds3_bit | output | 1 | Serial DS3 output bit |
| mf_start | output | 1 | Current bit is M-frame bit 0 |
| sf_idx | output | 3 | Current subframe, 0..6 |
| blk_idx | output | 3 | Current block, 0..7 |
| ovh_slot | output | 1 | Current bit is an overhead bit |

## Verification
Frame sync and back-pressure can land on the same bit time. So can frame sync and the final bit of an M-frame, where the parity store and the parity clear would both act. The bench raises `frame_sync` with `sync_en` set in a cycle where `ds3_ready` is randomly high or low. It then checks that the position stays at M-frame bit 0 until a transfer takes place. It also checks that the P bits of the next M-frame leave out the payload sent before the sync. In a separate case `frame_sync` is asserted with `sync_en` low, and the position and P bits must follow the undisturbed count.

// File: rtl/ds3_mf_pkg.sv
package ds3_mf_pkg;
  localparam int BLK_BITS_D = 85;
  localparam int BLKS_D     = 8;
  localparam int SFS_D      = 7;

  typedef enum logic {
    MODE_M13  = 1'b0,
    MODE_CBIT = 1'b1
  } ds3_mode_e;
endpackage

// File: rtl/ds3_mf_counter.sv
module ds3_mf_counter #(
  parameter int BLK_BITS = 85,
  parameter int BLKS     = 8,
  parameter int SFS      = 7,
  localparam int BW = $clog2(BLK_BITS),
  localparam int KW = $clog2(BLKS),
  localparam int SW = $clog2(SFS)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          adv,
  input  logic          sync,
  output logic [BW-1:0] bit_o,
  output logic [KW-1:0] blk_o,
  output logic [SW-1:0] sf_o,
  output logic          last_o
);
  logic [BW-1:0] bit_q;
  logic [KW-1:0] blk_q;
  logic [SW-1:0] sf_q;

  always_comb begin
    bit_o  = sync ? '0 : bit_q;
    blk_o  = sync ? '0 : blk_q;
    sf_o   = sync ? '0 : sf_q;
    last_o = (bit_o == BW'(BLK_BITS - 1)) && (blk_o == KW'(BLKS - 1)) &&
             (sf_o == SW'(SFS - 1));
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      bit_q <= '0;
      blk_q <= '0;
      sf_q  <= '0;
    end else if (adv) begin
      if (bit_o == BW'(BLK_BITS - 1)) begin
        bit_q <= '0;
        if (blk_o == KW'(BLKS - 1)) begin
          blk_q <= '0;
          sf_q  <= (sf_o == SW'(SFS - 1)) ? '0 : sf_o + 1'b1;
        end else begin
          blk_q <= blk_o + 1'b1;
          sf_q  <= sf_o;
        end
      end else begin
        bit_q <= bit_o + 1'b1;
        blk_q <= blk_o;
        sf_q  <= sf_o;
      end
    end else if (sync) begin
      bit_q <= '0;
      blk_q <= '0;
      sf_q  <= '0;
    end
  end

  p_bit_range_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (bit_q < BW'(BLK_BITS)) && (sf_q < SW'(SFS)));

  p_wrap_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && last_o) |=> (bit_q == '0 && blk_q == '0 && sf_q == '0));

  p_stall_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!adv && !sync) |=> ($stable(bit_q) && $stable(blk_q) && $stable(sf_q)));
endmodule

// File: rtl/ds3_oh_sel.sv
module ds3_oh_sel
  import ds3_mf_pkg::*;
#(
  parameter int BLKS = 8,
  parameter int SFS  = 7,
  localparam int KW  = $clog2(BLKS),
  localparam int SW  = $clog2(SFS),
  localparam int NC  = 3 * SFS
) (
  input  logic          mode,
  input  logic [KW-1:0] blk,
  input  logic [SW-1:0] sf,
  input  logic          x_bit,
  input  logic          p_bit,
  input  logic [NC-1:0] c_bits,
  input  logic [SFS-1:0] stuff_ind,
  output logic          oh_bit
);
  logic [KW-1:0] pair;
  logic [1:0]    c_n;
  int            c_idx;
  logic          first_bit, f_bit, c_val;

  always_comb begin
    pair  = blk >> 1;
    c_n   = 2'(pair - 1'b1);
    c_idx = 3 * int'(sf) + int'(c_n);

    if (sf < SW'(2))      first_bit = x_bit;
    else if (sf < SW'(4)) first_bit = p_bit;
    else                  first_bit = (sf == SW'(5));

    f_bit = (pair == '0) || (pair == KW'(3));

    if (ds3_mode_e'(mode) == MODE_CBIT)
      c_val = (c_idx == 0) ? 1'b1 : c_bits[c_idx];
    else
      c_val = stuff_ind[sf];

    if (blk == '0)    oh_bit = first_bit;
    else if (blk[0])  oh_bit = f_bit;
    else              oh_bit = c_val;
  end
endmodule

// File: rtl/ds3_parity_acc.sv
module ds3_parity_acc (
  input  logic clk,
  input  logic rst_n,
  input  logic take,
  input  logic din,
  input  logic frame_end,
  input  logic clr,
  output logic p_o
);
  logic acc_q, acc_n;

  always_comb acc_n = acc_q ^ (take & din);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      acc_q <= 1'b0;
      p_o   <= 1'b0;
    end else if (clr) begin
      acc_q <= 1'b0;
    end else if (frame_end) begin
      acc_q <= 1'b0;
      p_o   <= acc_n;
    end else begin
      acc_q <= acc_n;
    end
  end

  p_phold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!frame_end || clr) |=> $stable(p_o));

  p_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (acc_q == 1'b0));
endmodule

// File: rtl/ds3_mframe_gen.sv
module ds3_mframe_gen
  import ds3_mf_pkg::*;
#(
  parameter int BLK_BITS = BLK_BITS_D,
  parameter int BLKS     = BLKS_D,
  parameter int SFS      = SFS_D,
  localparam int BW = $clog2(BLK_BITS),
  localparam int KW = $clog2(BLKS),
  localparam int SW = $clog2(SFS),
  localparam int NC = 3 * SFS
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           mode,
  input  logic           x_bit,
  input  logic [NC-1:0]  c_bits,
  input  logic [SFS-1:0] stuff_ind,
  input  logic           sync_en,
  input  logic           frame_sync,
  input  logic           pl_valid,
  input  logic           pl_data,
  output logic           pl_ready,
  output logic           ds3_valid,
  input  logic           ds3_ready,
  output logic           ds3_bit,
  output logic           mf_start,
  output logic [SW-1:0]  sf_idx,
  output logic [KW-1:0]  blk_idx,
  output logic           ovh_slot
);
  logic          sync_eff, adv, last, oh_bit, p_bit;
  logic [BW-1:0] bit_pos;

  assign sync_eff = frame_sync & sync_en;

  ds3_mf_counter #(.BLK_BITS(BLK_BITS), .BLKS(BLKS), .SFS(SFS)) u_cnt (
    .clk(clk), .rst_n(rst_n), .adv(adv), .sync(sync_eff),
    .bit_o(bit_pos), .blk_o(blk_idx), .sf_o(sf_idx), .last_o(last)
  );

  ds3_oh_sel #(.BLKS(BLKS), .SFS(SFS)) u_sel (
    .mode(mode), .blk(blk_idx), .sf(sf_idx), .x_bit(x_bit), .p_bit(p_bit),
    .c_bits(c_bits), .stuff_ind(stuff_ind), .oh_bit(oh_bit)
  );

  ds3_parity_acc u_par (
    .clk(clk), .rst_n(rst_n), .take(adv & ~ovh_slot), .din(pl_data),
    .frame_end(adv & last), .clr(sync_eff), .p_o(p_bit)
  );

  always_comb begin
    ovh_slot  = (bit_pos == '0);
    mf_start  = ovh_slot && (blk_idx == '0) && (sf_idx == '0);
    ds3_valid = ovh_slot | pl_valid;
    ds3_bit   = ovh_slot ? oh_bit : pl_data;
    pl_ready  = ~ovh_slot & ds3_ready;
    adv       = ds3_valid & ds3_ready;
  end

  p_fbit_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (ovh_slot && blk_idx == KW'(1)) |-> ds3_bit);

  p_mbit_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (ovh_slot && blk_idx == '0 && sf_idx == SW'(5)) |-> ds3_bit);

  p_ready_r2: assert property (@(posedge clk) disable iff (!rst_n)
    pl_ready |-> (ds3_ready && !mf_start && ds3_valid == pl_valid));

  p_sync_r9: assert property (@(posedge clk) disable iff (!rst_n)
    sync_eff |-> (mf_start && ds3_valid));
endmodule

// File: tb/ds3_mframe_gen_tb_top.sv
`timescale 1ns/1ps
module ds3_mframe_gen_tb_top;
  logic clk = 1'b0, rst_n = 1'b0;
  logic mode = 1'b1, x_bit = 1'b1, sync_en = 1'b0, frame_sync = 1'b0;
  logic [20:0] c_bits = '0;
  logic [6:0]  stuff_ind = '0;
  logic pl_valid = 1'b0, pl_data = 1'b0, ds3_ready = 1'b0;
  logic pl_ready, ds3_valid, ds3_bit, mf_start, ovh_slot;
  logic [2:0] sf_idx, blk_idx;

  int n_tests = 0, n_fail = 0;
  bit done = 0;
  int pos = 0;
  logic acc = 1'b0, preg = 1'b0;
  bit stalled_prev = 0;

  always #2 clk = ~clk;

  ds3_mframe_gen dut_i (.*);

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d (pos %0d)", req, act, exp, pos);
    end
  endtask

  function automatic logic exp_oh(int sf, int blk, logic md, logic x, logic pr,
                                  logic [20:0] cb, logic [6:0] st);
    if (blk == 0) begin
      if (sf < 2) return x;
      if (sf < 4) return pr;
      return logic'(sf == 5);
    end
    if (blk % 2 == 1) return logic'(blk == 1 || blk == 7);
    if (md) return (sf == 0 && blk == 2) ? 1'b1 : cb[3*sf + blk/2 - 1];
    return st[sf];
  endfunction

  function automatic string oh_req(int sf, int blk, logic md);
    if (blk == 0) return (sf == 2 || sf == 3) ? "R5" : "R4";
    if (blk % 2 == 1) return "R3";
    return md ? "R6" : "R7";
  endfunction

  task automatic cyc(input int rdy_pct, input int val_pct, input logic sy,
                     input logic sen, input logic md);
    int p, sf, blk, b;
    bit ovh, sync_eff, ev, adv;
    logic eb;
    string preq;
    @(negedge clk);
    mode = md; frame_sync = sy; sync_en = sen;
    ds3_ready = ($urandom % 100) < rdy_pct;
    pl_valid  = ($urandom % 100) < val_pct;
    pl_data   = $urandom % 2;
    x_bit     = $urandom % 2;
    c_bits    = 21'($urandom);
    stuff_ind = 7'($urandom);
    #1;
    sync_eff = sy && sen;
    p   = sync_eff ? 0 : pos;
    sf  = p / 680; blk = (p % 680) / 85; b = p % 85;
    ovh = (b == 0);
    ev  = ovh || pl_valid;
    eb  = ovh ? exp_oh(sf, blk, md, x_bit, preg, c_bits, stuff_ind) : pl_data;
    chk(ds3_valid == ev, "R2 valid", ds3_valid, ev);
    chk(pl_ready == (!ovh && ds3_ready), "R2 ready", pl_ready, !ovh && ds3_ready);
    chk(ovh_slot == ovh, "R2 ovh", ovh_slot, ovh);
    if (ev) chk(ds3_bit == eb, ovh ? oh_req(sf, blk, md) : "R2 data", ds3_bit, eb);
    if (sync_eff)          preq = "R9 sync";
    else if (sy)           preq = "R10 sync ignored";
    else if (stalled_prev) preq = "R8 stall";
    else                   preq = "R1 position";
    chk(mf_start == (p == 0), preq, mf_start, p == 0);
    chk(sf_idx == 3'(sf) && blk_idx == 3'(blk), preq, {sf_idx, blk_idx}, {sf[2:0], blk[2:0]});
    @(posedge clk);
    adv = ev && ds3_ready;
    if (sync_eff) acc = 1'b0;
    if (adv) begin
      if (!ovh) acc = acc ^ pl_data;
      if (p == 4759) begin preg = acc; acc = 1'b0; pos = 0; end
      else pos = p + 1;
    end else pos = p;
    stalled_prev = !adv;
  endtask

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R11: reset state, first bit of frame with X bit
    chk(mf_start == 1'b1, "R11 start", mf_start, 1);
    chk(ds3_valid == 1'b1 && ds3_bit == x_bit, "R11 first bit", ds3_bit, x_bit);
    rst_n = 1'b1;
    // Full throughput, C-bit mode: P stays 0 in the first frame (R11/R5)
    repeat (6000)  cyc(100, 100, 0, 0, 1);
    // Random back-pressure, C-bit mode (R6, R8)
    repeat (12000) cyc(75, 80, 0, 0, 1);
    // M13 mode (R7)
    repeat (12000) cyc(80, 85, 0, 0, 0);
    // R10: sync ignored when disabled
    repeat (300) cyc(80, 80, 0, 0, 1);
    cyc(80, 80, 1, 0, 1);
    repeat (50) cyc(80, 80, 0, 0, 1);
    // R9: sync under a stall, then under a transfer
    cyc(0, 80, 1, 1, 1);
    cyc(0, 80, 0, 0, 1);
    repeat (2000) cyc(90, 90, 0, 0, 1);
    cyc(100, 100, 1, 1, 0);
    // Mixed: random mode, rare random syncs
    for (int i = 0; i < 30000; i++)
      cyc(85, 85, ($urandom % 4000) == 0, $urandom % 2, $urandom % 2);
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    #(200000 * 4);
    if (!done) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule